// File: doc/BRIEF.md
# Presettable Decade Counter with Modulo-N Truncation

This block is a four-bit synchronous counting stage that steps through 0 to 9 and then returns to 0. It has four controls. An active-low clear acts at once and does not wait for the clock. An active-low load copies a four-bit value on the rising edge. There are two count enables. A carry output lets several stages be chained into a wider decimal counter: the carry of one stage drives an enable of the next.

Around the stage, the same module builds a modulo-N counter, chosen at elaboration time by two parameters, in one of two ways.

- **Load truncation:** the terminal state N-1 is decoded and drives the synchronous load with the value zero. The sequence is 0 to N-1 and has no extra states.
- **Clear truncation:** state N itself is decoded and drives the asynchronous clear. State N appears only for an instant after the clock edge and is never held as a count.

External load and clear remain usable in both variants.

Top module: `decade_modn_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0 immediately, without any clock edge, and loads and enables are ignored.
- R2: When `load_n` is low at a rising edge, `count` takes `data_in`, whatever the enables are. This includes values 10 to 15.
- R3: With both enables high and `load_n` high, each rising edge advances `count` by one, from 0 to 9 and then to 0.
- R4: With `load_n` high and either enable low, `count` holds its value across edges.
- R5: From any state from 10 to 15, an enabled edge (both enables high, `load_n` high) moves `count` to 0.
- R6: `carry` is high exactly when `count` is 9 and `chain_en` is high. `cnt_en` has no effect on `carry`.
- R7: When `carry` is high and `cnt_en` is high with `load_n` high, the next edge returns `count` to 0.
- R8: With `CLEAR_TRUNC` = 0, enabled edges give the sequence 0 to N-1 and then 0. At N-1 with either enable low, the count holds.
- R9: With `CLEAR_TRUNC` = 1, enabled edges give 0 to N-1 and then 0 as seen after each edge. State N is never stable and is cleared at once.
- R10: With `CLEAR_TRUNC` = 1, an external load of the value N leaves `count` at 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | 4 | Value taken on a load |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| chain_en | input | 1 | Count enable that also gates the carry |
| count | output | 4 | Present count |
| carry | output | 1 | High at count 9 while `chain_en` is high |

## Verification
The in-module assertions check the following relations on every edge:
- hold when an enable is low;
- load of the data value;
- increment below the wrap point;
- return to 0 at the wrap point and after a carry;
- recovery from states 10 to 15.

Other behaviours can only be shown by the bench's directed scenarios:
- the instant effect of the clear between clock edges;
- the vanishing of state N in clear truncation;
- the carry's independence from `cnt_en`;
- the full sequences of three differently parameterised instances running side by side.

// File: rtl/decade_modn_counter.sv
module decade_modn_counter #(
  parameter int N           = 10,
  parameter bit CLEAR_TRUNC = 1'b0
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic [3:0] data_in,
  input  logic       cnt_en,
  input  logic       chain_en,
  output logic [3:0] count,
  output logic       carry
);
  localparam logic [3:0] LAST = 4'(N - 1);
  localparam logic [3:0] WRAP = 4'(N);

  logic       run;
  logic       eff_clr_n;
  logic       eff_load_n;
  logic [3:0] load_val;
  logic [3:0] next_val;

  assign run      = cnt_en & chain_en;
  assign next_val = (count >= 4'd9) ? 4'd0 : count + 4'd1;
  assign carry    = (count == 4'd9) & chain_en;

  generate
    if (CLEAR_TRUNC) begin : g_clear_trunc
      assign eff_clr_n  = clr_n & (count != WRAP);
      assign eff_load_n = load_n;
      assign load_val   = data_in;
    end else begin : g_load_trunc
      assign eff_clr_n  = clr_n;
      assign eff_load_n = load_n & ~(run & (count == LAST));
      assign load_val   = load_n ? 4'd0 : data_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge eff_clr_n) begin
    if (!eff_clr_n)      count <= 4'd0;
    else if (!eff_load_n) count <= load_val;
    else if (run)         count <= next_val;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !run) |=> $stable(count));

  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n && (!CLEAR_TRUNC || data_in != WRAP)) |=> count == $past(data_in));

  assert_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && run && count < 4'd9 && (32'(count) + 1 < N)) |=> count == $past(count) + 4'd1);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && run && count == LAST) |=> count == 4'd0);

  assert_chain_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (carry && cnt_en && load_n) |=> count == 4'd0);

  assert_illegal_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && run && count > 4'd9) |=> count == 4'd0);
endmodule

// File: tb/test_decade_modn_counter.sv
module test_decade_modn_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] data_in = 4'd0;
  logic [3:0] q_dec, q_ld, q_cl;
  logic       c_dec, c_ld, c_cl;
  int total = 0, fails = 0;

  decade_modn_counter #(.N(10), .CLEAR_TRUNC(1'b0)) i_decade_modn_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(q_dec), .carry(c_dec));
  decade_modn_counter #(.N(7), .CLEAR_TRUNC(1'b0)) i_decade_modn_counter_ld7 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(q_ld), .carry(c_ld));
  decade_modn_counter #(.N(7), .CLEAR_TRUNC(1'b1)) i_decade_modn_counter_cl7 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(q_cl), .carry(c_cl));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic load_all(input logic [3:0] v);
    data_in = v; load_n = 1'b0; step(); load_n = 1'b1;
  endtask

  task automatic t_reset;
    #1 clr_n = 1'b0;
    #1 chk("R1 reset dec", q_dec, 4'd0);
    chk("R1 reset ld", q_ld, 4'd0);
    chk("R1 reset cl", q_cl, 4'd0);
    step();
    clr_n = 1'b1;
  endtask

  task automatic t_sequences;
    cnt_en = 1'b1; chain_en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      step();
      chk("R3 decade seq", q_dec, 4'(i % 10));
      chk("R8 load-trunc seq", q_ld, 4'(i % 7));
      chk("R9 clear-trunc seq", q_cl, 4'(i % 7));
    end
  endtask

  task automatic t_hold;
    cnt_en = 1'b0; step(); step();
    chk("R4 hold cnt_en low", q_dec, 4'd2);
    chk("R4 hold cnt_en low ld", q_ld, 4'd5);
    cnt_en = 1'b1; chain_en = 1'b0; step();
    chk("R4 hold chain_en low", q_dec, 4'd2);
    chk("R4 hold chain_en low cl", q_cl, 4'd5);
  endtask

  task automatic t_load;
    cnt_en = 1'b0; chain_en = 1'b0;
    load_all(4'd5);
    chk("R2 load enables low", q_dec, 4'd5);
    chk("R2 load enables low ld", q_ld, 4'd5);
    cnt_en = 1'b1; chain_en = 1'b1;
    load_all(4'd3);
    chk("R2 load beats count", q_dec, 4'd3);
    chk("R2 load beats count cl", q_cl, 4'd3);
  endtask

  task automatic t_carry;
    cnt_en = 1'b0; chain_en = 1'b0;
    load_all(4'd9);
    chain_en = 1'b1;
    #1 chk("R6 carry with cnt_en low", 4'(c_dec), 4'd1);
    chk("R6 count held at 9", q_dec, 4'd9);
    chain_en = 1'b0; cnt_en = 1'b1;
    #1 chk("R6 carry off with chain_en low", 4'(c_dec), 4'd0);
    chain_en = 1'b1;
    #1 chk("R6 carry on", 4'(c_dec), 4'd1);
    step();
    chk("R7 wrap after carry", q_dec, 4'd0);
    chk("R7 carry drops", 4'(c_dec), 4'd0);
    chk("R3 clear-trunc 9 wraps", q_cl, 4'd0);
  endtask

  task automatic t_illegal;
    cnt_en = 1'b0; chain_en = 1'b0;
    load_all(4'd12);
    chk("R2 load 12", q_dec, 4'd12);
    cnt_en = 1'b1; chain_en = 1'b1; step();
    chk("R5 12 to 0", q_dec, 4'd0);
    chk("R5 12 to 0 ld", q_ld, 4'd0);
    chk("R5 12 to 0 cl", q_cl, 4'd0);
    cnt_en = 1'b0;
    load_all(4'd15);
    cnt_en = 1'b1; step();
    chk("R5 15 to 0", q_dec, 4'd0);
  endtask

  task automatic t_terminal;
    cnt_en = 1'b0; chain_en = 1'b1;
    load_all(4'd6);
    step();
    chk("R8 held at N-1", q_ld, 4'd6);
    cnt_en = 1'b1; step();
    chk("R8 wrap from N-1", q_ld, 4'd0);
    chk("R9 N vanishes", q_cl, 4'd0);
    chk("R3 decade continues", q_dec, 4'd7);
  endtask

  task automatic t_clear_load_n;
    cnt_en = 1'b0;
    load_all(4'd7);
    chk("R10 load of N cleared", q_cl, 4'd0);
    chk("R2 load-trunc takes 7", q_ld, 4'd7);
    cnt_en = 1'b1; step();
    chk("R3 7 to 8", q_dec, 4'd8);
  endtask

  task automatic t_async;
    #1 clr_n = 1'b0;
    #1 chk("R1 clear between edges", q_dec, 4'd0);
    chk("R1 clear between edges ld", q_ld, 4'd0);
    data_in = 4'd5; load_n = 1'b0; step();
    chk("R1 load ignored in clear", q_dec, 4'd0);
    clr_n = 1'b1; load_n = 1'b1; step();
    chk("R3 count after clear", q_dec, 4'd1);
  endtask

  initial begin
    t_reset();
    t_sequences();
    t_hold();
    t_load();
    t_carry();
    t_illegal();
    t_terminal();
    t_clear_load_n();
    t_async();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule